// File: doc/BRIEF.md
# Strobe-Timed Data Overdrive Sequencer

The sequencer listens passively to two strobe lines of a host bus and, at a precisely chosen moment, takes over a shared data line for a short window before handing it back in high impedance. After reset it first locks onto a clean rising edge of the primary strobe. It then looks for a configured number of quiet gaps on that strobe. A quiet gap is a run of consecutive low samples, and any activity cancels the run and starts it again. When the gaps are found it arms an edge counter, waits for the target rising edge, lets a fixed offset pass, and drives the data line for a fixed width.

In two-stage mode a second pass follows. It qualifies quiet gaps on the primary strobe again, against its own gap target. It then counts falling edges of the secondary strobe to its own pulse target and injects a second window with its own offset and width. An active-low bypass input is read once at start, and a low level there keeps the whole block idle. Both strobes pass through a two-flop synchronizer. Every threshold, count and delay is a parameter expressed in system clock cycles.

Top module: `ovd_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `dataOe`, `dataOut` and `busy` are 0 and `status` is 0.
- R2: The block waits a settling time of 3 cycles and then reads the synchronized primary strobe. If the strobe is high, the block waits for a fall and then a rise. If it is low, the block waits only for a rise. No gap is counted before that rise, however long the strobe stays low.
- R3: A quiet gap counts only after GAP_LEN consecutive low samples of the synchronized primary strobe. A high sample discards the partial gap, and counting resumes only after the strobe has gone low again. Any number of pulses with low spells shorter than GAP_LEN never arms the block.
- R4: Once CONF1 gaps have been counted, stage one arms and `busy` rises. A pulse counter is loaded with PULSE1.
- R5: In stage one each synchronized rising edge of `strbA` counts down by one. The injection fires on the PULSE1-th edge, and no earlier edge drives the line.
- R6: The injection starts OFS1 cycles after the edge is detected. With the synchronizer included, `dataOe` goes high OFS1+3 clock samples after the input rises. It stays high for exactly WID1 cycles and then returns to 0, which means released.
- R7: `dataOut` is 0 whenever `dataOe` is 0. In two-stage mode the stage-one window drives 1. Every other window drives DRIVE_VAL, which defaults to 0.
- R8: In two-stage mode, stage two qualifies CONF2 gaps on `strbA` under the R3 rules. It then counts PULSE2 falling edges of `strbB`, fires OFS2 cycles after the last one (OFS2+3 samples from the input fall), and drives for WID2 cycles.
- R9: `bypassN` is read only at the end of the settling time. If it is 0, the block never drives the line and never raises `busy`. Later changes of `bypassN` have no effect.
- R10: `busy` is 1 from arming until the end of that stage's window. `status` is 0 while idle, 1 after the stage-one window ends, and 2 after the stage-two window ends. `status` changes only in the cycle where a window ends.
- R11: After the last stage has completed, the block keeps `dataOe` at 0 and `busy` at 0 and holds `status` until reset, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strbA | input | 1 | Primary strobe (asynchronous); used for alignment, gaps and stage-one edges |
| strbB | input | 1 | Secondary strobe (asynchronous); its falling edges are counted in stage two |
| bypassN | input | 1 | Active-low bypass, read once at start |
| dataOut | output | 1 | Value driven onto the data line |
| dataOe | output | 1 | Drive enable for the data line; 0 means high impedance |
| busy | output | 1 | High while a stage is armed or injecting |
| status | output | 2 | 0 idle, 1 stage one done, 2 stage two done |

## Verification
Two instances, one single-stage and one two-stage, receive the same stimulus and are compared every cycle against a behavioural model. Alignment is tried with the strobe low at start and with it high at start, each followed by a long low spell, so that a design that skips the fall-then-rise wait arms too early. Bursts of pulses with low spells shorter than the gap length show whether gap runs are discarded or only paused. Edge trains spaced far apart measure the edge count, the offset latency and the window width of each stage separately. Bypass runs and strobe activity after completion show that neither reaches the data line.

// File: rtl/ovd_pkg.sv
package ovd_pkg;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_BYPASS,
    ST_ALFALL,
    ST_ALRISE,
    ST_GAP,
    ST_GAPHOLD,
    ST_COUNT,
    ST_OFS,
    ST_DRIVE,
    ST_DONE
  } ovdState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic gapClr;
    logic gapInc;
    logic confClr;
    logic confInc;
    logic pulseLoad;
    logic pulseDec;
    logic tmrClr;
    logic tmrInc;
    logic stageTwo;
  } ovdCmd_t;

  // datapath -> control flags
  typedef struct packed {
    logic aLvl;
    logic aRise;
    logic aFall;
    logic bFall;
    logic gapFull;
    logic confLast;
    logic pulseLast;
    logic tmrSettle;
    logic tmrOfs;
    logic tmrWid;
  } ovdFlag_t;

  localparam int SETTLE_CYC = 3;

endpackage

// File: rtl/ovd_dp.sv
module ovd_dp
  import ovd_pkg::*;
#(
  parameter int CW     = 16,
  parameter int GAP_LEN = 8,
  parameter int CONF1  = 3,
  parameter int CONF2  = 2,
  parameter int PULSE1 = 4,
  parameter int PULSE2 = 3,
  parameter int OFS1   = 5,
  parameter int WID1   = 4,
  parameter int OFS2   = 3,
  parameter int WID2   = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     strbA,
  input  logic     strbB,
  input  ovdCmd_t  cmd,
  output ovdFlag_t flag
);

  localparam int NLINE = 2;
  localparam logic [CW-1:0] GAP_M1   = CW'(GAP_LEN - 1);
  localparam logic [CW-1:0] CONF1_M1 = CW'(CONF1 - 1);
  localparam logic [CW-1:0] CONF2_M1 = CW'(CONF2 - 1);
  localparam logic [CW-1:0] PULSE1_V = CW'(PULSE1);
  localparam logic [CW-1:0] PULSE2_V = CW'(PULSE2);
  localparam logic [CW-1:0] OFS1_M1  = CW'(OFS1 - 1);
  localparam logic [CW-1:0] OFS2_M1  = CW'(OFS2 - 1);
  localparam logic [CW-1:0] WID1_M1  = CW'(WID1 - 1);
  localparam logic [CW-1:0] WID2_M1  = CW'(WID2 - 1);
  localparam logic [CW-1:0] SET_M1   = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [NLINE-1:0] rawIn;
  logic [NLINE-1:0] lineLvl;
  logic [NLINE-1:0] lineRise;
  logic [NLINE-1:0] lineFall;

  assign rawIn = {strbB, strbA};

  // two-flop synchronizer plus edge detect, one per strobe line
  for (genvar g = 0; g < NLINE; g++) begin : gSync
    logic metaQ, lvlQ, prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaQ <= 1'b0;
        lvlQ  <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        metaQ <= rawIn[g];
        lvlQ  <= metaQ;
        prevQ <= lvlQ;
      end
    end
    assign lineLvl[g]  = lvlQ;
    assign lineRise[g] = lvlQ & ~prevQ;
    assign lineFall[g] = ~lvlQ & prevQ;
  end

  logic [CW-1:0] gapCnt, confCnt, pulseCnt, tmrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (cmd.gapClr) begin
      gapCnt <= '0;
    end else if (cmd.gapInc) begin
      gapCnt <= gapCnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      confCnt <= '0;
    end else if (cmd.confClr) begin
      confCnt <= '0;
    end else if (cmd.confInc) begin
      confCnt <= confCnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (cmd.pulseLoad) begin
      pulseCnt <= cmd.stageTwo ? PULSE2_V : PULSE1_V;
    end else if (cmd.pulseDec) begin
      pulseCnt <= pulseCnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (cmd.tmrClr) begin
      tmrCnt <= '0;
    end else if (cmd.tmrInc) begin
      tmrCnt <= tmrCnt + ONE;
    end
  end

  logic [CW-1:0] confSel, ofsSel, widSel;
  assign confSel = cmd.stageTwo ? CONF2_M1 : CONF1_M1;
  assign ofsSel  = cmd.stageTwo ? OFS2_M1  : OFS1_M1;
  assign widSel  = cmd.stageTwo ? WID2_M1  : WID1_M1;

  always_comb begin
    flag.aLvl      = lineLvl[0];
    flag.aRise     = lineRise[0];
    flag.aFall     = lineFall[0];
    flag.bFall     = lineFall[1];
    flag.gapFull   = (gapCnt == GAP_M1);
    flag.confLast  = (confCnt == confSel);
    flag.pulseLast = (pulseCnt == ONE);
    flag.tmrSettle = (tmrCnt == SET_M1);
    flag.tmrOfs    = (tmrCnt == ofsSel);
    flag.tmrWid    = (tmrCnt == widSel);
  end

endmodule

// File: rtl/ovd_ctrl.sv
module ovd_ctrl
  import ovd_pkg::*;
#(
  parameter bit TWO_STAGE = 1'b1,
  parameter bit DRIVE_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bypassN,
  input  ovdFlag_t   flag,
  output ovdCmd_t    cmd,
  output logic       dataOut,
  output logic       dataOe,
  output logic       busy,
  output logic [1:0] status
);

  ovdState_e stateQ, stateD;
  logic      stageQ, stageD;
  logic [1:0] statusQ, statusD;
  logic      edgeHit;

  assign edgeHit = stageQ ? flag.bFall : flag.aRise;

  always_comb begin
    stateD  = stateQ;
    stageD  = stageQ;
    statusD = statusQ;
    cmd          = '0;
    cmd.stageTwo = stageQ;
    unique case (stateQ)
      ST_SETTLE: begin
        if (flag.tmrSettle) begin
          cmd.tmrClr = 1'b1;
          if (!bypassN)       stateD = ST_BYPASS;
          else if (flag.aLvl) stateD = ST_ALFALL;
          else                stateD = ST_ALRISE;
        end else begin
          cmd.tmrInc = 1'b1;
        end
      end
      ST_BYPASS: stateD = ST_BYPASS;
      ST_ALFALL: if (flag.aFall) stateD = ST_ALRISE;
      ST_ALRISE: begin
        if (flag.aRise) begin
          stateD      = ST_GAP;
          cmd.gapClr  = 1'b1;
          cmd.confClr = 1'b1;
        end
      end
      ST_GAP: begin
        if (flag.aLvl) begin
          stateD     = ST_GAPHOLD;
          cmd.gapClr = 1'b1;
        end else if (flag.gapFull) begin
          cmd.gapClr  = 1'b1;
          cmd.confInc = 1'b1;
          if (flag.confLast) begin
            stateD        = ST_COUNT;
            cmd.pulseLoad = 1'b1;
          end
        end else begin
          cmd.gapInc = 1'b1;
        end
      end
      ST_GAPHOLD: if (!flag.aLvl) stateD = ST_GAP;
      ST_COUNT: begin
        if (edgeHit) begin
          if (flag.pulseLast) begin
            stateD     = ST_OFS;
            cmd.tmrClr = 1'b1;
          end else begin
            cmd.pulseDec = 1'b1;
          end
        end
      end
      ST_OFS: begin
        if (flag.tmrOfs) begin
          stateD     = ST_DRIVE;
          cmd.tmrClr = 1'b1;
        end else begin
          cmd.tmrInc = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (flag.tmrWid) begin
          cmd.tmrClr = 1'b1;
          if (TWO_STAGE && !stageQ) begin
            stateD      = ST_GAP;
            stageD      = 1'b1;
            statusD     = 2'd1;
            cmd.gapClr  = 1'b1;
            cmd.confClr = 1'b1;
          end else begin
            stateD  = ST_DONE;
            statusD = stageQ ? 2'd2 : 2'd1;
          end
        end else begin
          cmd.tmrInc = 1'b1;
        end
      end
      ST_DONE: stateD = ST_DONE;
      default: stateD = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_SETTLE;
      stageQ  <= 1'b0;
      statusQ <= 2'd0;
    end else begin
      stateQ  <= stateD;
      stageQ  <= stageD;
      statusQ <= statusD;
    end
  end

  logic driveLvl;
  assign driveLvl = (TWO_STAGE && !stageQ) ? 1'b1 : DRIVE_VAL;

  assign dataOe  = (stateQ == ST_DRIVE);
  assign dataOut = dataOe & driveLvl;
  assign busy    = (stateQ == ST_COUNT) || (stateQ == ST_OFS) || (stateQ == ST_DRIVE);
  assign status  = statusQ;

endmodule

// File: rtl/ovd_seq_top.sv
module ovd_seq_top
  import ovd_pkg::*;
#(
  parameter int CW        = 16,
  parameter int GAP_LEN   = 8,
  parameter int CONF1     = 3,
  parameter int CONF2     = 2,
  parameter int PULSE1    = 4,
  parameter int PULSE2    = 3,
  parameter int OFS1      = 5,
  parameter int WID1      = 4,
  parameter int OFS2      = 3,
  parameter int WID2      = 6,
  parameter bit TWO_STAGE = 1'b1,
  parameter bit DRIVE_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strbA,
  input  logic       strbB,
  input  logic       bypassN,
  output logic       dataOut,
  output logic       dataOe,
  output logic       busy,
  output logic [1:0] status
);

  ovdCmd_t  cmd;
  ovdFlag_t flag;

  ovd_dp #(
    .CW(CW), .GAP_LEN(GAP_LEN), .CONF1(CONF1), .CONF2(CONF2),
    .PULSE1(PULSE1), .PULSE2(PULSE2), .OFS1(OFS1), .WID1(WID1),
    .OFS2(OFS2), .WID2(WID2)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strbA(strbA), .strbB(strbB),
    .cmd(cmd), .flag(flag)
  );

  ovd_ctrl #(
    .TWO_STAGE(TWO_STAGE), .DRIVE_VAL(DRIVE_VAL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .bypassN(bypassN), .flag(flag), .cmd(cmd),
    .dataOut(dataOut), .dataOe(dataOe), .busy(busy), .status(status)
  );

endmodule

// File: rtl/ovd_seq_chk.sv
module ovd_seq_chk #(
  parameter int WID1 = 4,
  parameter int WID2 = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       dataOut,
  input logic       dataOe,
  input logic       busy,
  input logic [1:0] status
);

  localparam int MAXW = (WID1 > WID2) ? WID1 : WID2;

  logic [15:0] oeRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       oeRun <= '0;
    else if (dataOe) oeRun <= oeRun + 16'd1;
    else             oeRun <= '0;
  end

  AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> !dataOut); // R7

  AST_ARMED_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(busy)); // R4

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (oeRun < 16'(MAXW))); // R6

  AST_STATUS_ON_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (status != $past(status)) |-> $fell(dataOe)); // R10

  AST_IDLE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOe) |-> !busy); // R10

  AST_FINAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd2) |-> (!dataOe && !busy)); // R11

endmodule

bind ovd_seq_top ovd_seq_chk #(.WID1(WID1), .WID2(WID2)) i_chk (
  .clk(clk), .rstN(rstN), .dataOut(dataOut), .dataOe(dataOe),
  .busy(busy), .status(status)
);

// File: tb/test_ovd_seq_top.sv
`timescale 1ns/1ps

module ovd_ref #(
  parameter int GAP_LEN = 8, parameter int CONF1 = 3, parameter int CONF2 = 2,
  parameter int PULSE1 = 4, parameter int PULSE2 = 3,
  parameter int OFS1 = 5, parameter int WID1 = 4,
  parameter int OFS2 = 3, parameter int WID2 = 6,
  parameter bit TWO = 1'b1, parameter bit DV = 1'b0
) (
  input  logic clk, input logic rstN,
  input  logic a, input logic b, input logic byN,
  output int   expOe, output int expOut, output int expBusy, output int expStatus
);
  int a1, a2, ap, b1, b2, bp;
  int ph, n, gaps, left, stg, st;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      a1 = 0; a2 = 0; ap = 0; b1 = 0; b2 = 0; bp = 0;
      ph = 0; n = 0; gaps = 0; left = 0; stg = 0; st = 0;
    end else begin
      int lvA, upA, dnA, dnB, hit;
      lvA = a2; upA = (a2 == 1 && ap == 0); dnA = (a2 == 0 && ap == 1);
      dnB = (b2 == 0 && bp == 1);
      ap = a2; a2 = a1; a1 = int'(a);
      bp = b2; b2 = b1; b1 = int'(b);
      case (ph)
        0: begin n++; if (n == 3) begin n = 0; ph = (!byN) ? 1 : (lvA != 0 ? 2 : 3); end end
        2: if (dnA) ph = 3;
        3: if (upA) begin ph = 4; n = 0; gaps = 0; end
        4: if (lvA != 0) begin ph = 5; n = 0; end
           else begin
             n++;
             if (n == GAP_LEN) begin
               n = 0; gaps++;
               if (gaps == (stg != 0 ? CONF2 : CONF1)) begin ph = 6; left = (stg != 0) ? PULSE2 : PULSE1; end
             end
           end
        5: if (lvA == 0) ph = 4;
        6: begin
             hit = (stg != 0) ? dnB : upA;
             if (hit != 0) begin left--; if (left == 0) begin ph = 7; n = 0; end end
           end
        7: begin n++; if (n == ((stg != 0) ? OFS2 : OFS1)) begin ph = 8; n = 0; end end
        8: begin
             n++;
             if (n == ((stg != 0) ? WID2 : WID1)) begin
               n = 0;
               if (TWO && stg == 0) begin stg = 1; ph = 4; gaps = 0; st = 1; end
               else begin ph = 9; st = (stg != 0) ? 2 : 1; end
             end
           end
        default: ;
      endcase
    end
  end

  assign expOe     = (ph == 8) ? 1 : 0;
  assign expOut    = (ph == 8) ? ((TWO && stg == 0) ? 1 : int'(DV)) : 0;
  assign expBusy   = (ph >= 6 && ph <= 8) ? 1 : 0;
  assign expStatus = st;
endmodule

module test_ovd_seq_top;
  localparam int OFS1 = 5, WID1 = 4, OFS2 = 3, WID2 = 6;

  logic clk = 0, rstN = 0, strbA = 0, strbB = 1, bypassN = 1;
  logic out2, oe2, busy2, out1, oe1, busy1;
  logic [1:0] st2, st1;
  int eOe2, eOut2, eBusy2, eSt2, eOe1, eOut1, eBusy1, eSt1;
  int tests = 0, fails = 0;
  int oe1Hi = 0, oe2Hi = 0;

  always #5 clk = ~clk;

  ovd_seq_top #(.TWO_STAGE(1'b1)) i_ovd_seq_top (
    .clk(clk), .rstN(rstN), .strbA(strbA), .strbB(strbB), .bypassN(bypassN),
    .dataOut(out2), .dataOe(oe2), .busy(busy2), .status(st2));
  ovd_seq_top #(.TWO_STAGE(1'b0)) i_ovd_seq_top_single (
    .clk(clk), .rstN(rstN), .strbA(strbA), .strbB(strbB), .bypassN(bypassN),
    .dataOut(out1), .dataOe(oe1), .busy(busy1), .status(st1));

  ovd_ref #(.TWO(1'b1)) i_ref2 (.clk(clk), .rstN(rstN), .a(strbA), .b(strbB), .byN(bypassN),
    .expOe(eOe2), .expOut(eOut2), .expBusy(eBusy2), .expStatus(eSt2));
  ovd_ref #(.TWO(1'b0)) i_ref1 (.clk(clk), .rstN(rstN), .a(strbA), .b(strbB), .byN(bypassN),
    .expOe(eOe1), .expOut(eOut1), .expBusy(eBusy1), .expStatus(eSt1));

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rstN) begin
      chk("R6 oe two-stage", int'(oe2), eOe2);
      chk("R7 out two-stage", int'(out2), eOut2);
      chk("R10 busy two-stage", int'(busy2), eBusy2);
      chk("R10 status two-stage", int'(st2), eSt2);
      chk("R6 oe single", int'(oe1), eOe1);
      chk("R7 out single", int'(out1), eOut1);
      chk("R10 busy single", int'(busy1), eBusy1);
      chk("R10 status single", int'(st1), eSt1);
      if (oe1) oe1Hi++;
      if (oe2) oe2Hi++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(logic a0, logic b0, logic by0);
    @(negedge clk);
    rstN = 0; strbA = a0; strbB = b0; bypassN = by0;
    idle(4);
    chk("R1 reset oe", int'(oe2) + int'(oe1), 0);
    chk("R1 reset out/busy", int'(out2) + int'(busy2) + int'(busy1), 0);
    chk("R1 reset status", int'(st2) + int'(st1), 0);
    rstN = 1;
    idle(1);
    chk("R1 post-reset outputs", int'(oe2) + int'(busy2) + int'(st2), 0);
    idle(5);
  endtask

  task automatic pulseA(int hi, int lo);
    strbA = 1; idle(hi); strbA = 0; idle(lo);
  endtask

  initial begin
    int k, w, hold;
    // ---------- scenario 1: strobe low at start, full two-stage run ----------
    doReset(1'b0, 1'b1, 1'b1);
    idle(40);
    chk("R2 no arm before first rise", int'(busy2) + int'(busy1), 0);
    bypassN = 0;                        // R9: late bypass is ignored
    for (int i = 0; i < 6; i++) pulseA(3, 5);
    chk("R3 short gaps never arm", int'(busy2) + int'(busy1), 0);
    idle(40);
    chk("R4 armed after CONF1 gaps", int'(busy2) + int'(busy1), 2);
    for (int i = 0; i < 3; i++) pulseA(3, 17);
    chk("R5 no drive before PULSE1-th edge", oe2Hi + oe1Hi, 0);
    k = 0; strbA = 1;
    while (!oe2 && k < 100) begin idle(1); k++; if (k == 3) strbA = 0; end
    chk("R6 stage-one latency", k, OFS1 + 3);
    chk("R7 stage-one level in two-stage mode", int'(out2), 1);
    chk("R7 single-stage default level", int'(out1), 0);
    chk("R9 late bypass ignored", int'(oe1), 1);
    w = 0;
    while (oe2 && w < 100) begin w++; idle(1); end
    chk("R6 stage-one width", w, WID1);
    chk("R10 status after stage one", int'(st2) * 4 + int'(st1), 5);
    chk("R10 busy cleared after stage one", int'(busy2) + int'(busy1), 0);
    idle(30);
    chk("R8 stage two armed", int'(busy2), 1);
    hold = oe1Hi;
    for (int i = 0; i < 2; i++) begin
      strbB = 0; idle(3); strbB = 1; idle(17);
    end
    chk("R8 no drive before PULSE2-th fall", int'(oe2), 0);
    k = 0; strbB = 0;
    while (!oe2 && k < 100) begin idle(1); k++; if (k == 3) strbB = 1; end
    chk("R8 stage-two latency", k, OFS2 + 3);
    chk("R7 stage-two default level", int'(out2), 0);
    w = 0;
    while (oe2 && w < 100) begin w++; idle(1); end
    chk("R8 stage-two width", w, WID2);
    chk("R10 status after stage two", int'(st2), 2);
    chk("R11 single-stage stays quiet", oe1Hi - hold, 0);
    hold = oe2Hi;
    for (int i = 0; i < 4; i++) begin
      pulseA(3, 15); strbB = 0; idle(3); strbB = 1; idle(15);
    end
    chk("R11 no drive after completion", oe2Hi - hold + int'(busy2), 0);
    chk("R11 status held", int'(st2) * 4 + int'(st1), 9);

    // ---------- scenario 2: strobe high at start ----------
    doReset(1'b1, 1'b1, 1'b1);
    idle(10);
    strbA = 0;
    idle(40);
    chk("R2 high start needs fall then rise", int'(busy2) + int'(busy1), 0);
    pulseA(3, 40);
    chk("R2 armed after fall-rise alignment", int'(busy2) + int'(busy1), 2);

    // ---------- scenario 3: bypass low at start ----------
    doReset(1'b0, 1'b1, 1'b0);
    idle(5);
    bypassN = 1;
    hold = oe2Hi + oe1Hi;
    pulseA(3, 40);
    for (int i = 0; i < 5; i++) pulseA(3, 17);
    chk("R9 bypass keeps block idle", int'(busy2) + int'(busy1) + oe2Hi + oe1Hi - hold, 0);
    chk("R9 bypass status idle", int'(st2) + int'(st1), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule